// File: doc/BRIEF.md
# Checkerboard Video Output Stage with Sync Alignment

This block sits between a raster timing generator and a pipelined RGB video converter. The generator supplies the current pixel column and line number, together with active-low horizontal and vertical sync and blanking flags. From these the block builds a two-colour checkerboard as three 8-bit colour channels. It also forms an active-low blanking strobe and an active-low composite sync for the converter, and provides the converter with an inverted pixel clock.

The horizontal and vertical sync pins go straight to the monitor and do not pass through the converter. The converter adds latency to the colour path, so the block delays each of these two syncs by a fixed number of pixel clocks. That keeps them aligned with the picture that leaves the converter. Colour, blanking and composite sync are registered once, on the same clock edge at which the counts are sampled.

Top module: `vga_dac_align`

## Requirements
- R1: Each colour tile is 64 pixels wide and 48 lines tall. The tile parity is ((pix_x/64)+(line_y/48)) mod 2. An even parity gives red=0x20, green=0xC0, blue=0xF0. An odd parity gives red=0xF0, green=0x80, blue=0x10. The colour appears one clock after the counts are sampled.
- R2: One clock after sampling, dac_blank_n equals the AND of hblank_n_in and vblank_n_in.
- R3: One clock after sampling, dac_sync_n equals the inverse of (hsync_n_in XOR vsync_n_in).
- R4: hsync_n_out and vsync_n_out repeat hsync_n_in and vsync_n_in exactly two clocks later.
- R5: When hblank_n_in or vblank_n_in is 0, red, green and blue are all 0 one clock later.
- R6: dac_clk is the logical inverse of clk.
- R7: While rst is high at a clock edge, the block sets red, green and blue to 0, dac_blank_n to 0, and dac_sync_n, hsync_n_out and vsync_n_out to 1.
- R8: The colour depends only on pix_x and line_y. Changing the sync inputs leaves red, green and blue unchanged.
- R9: Tile edges fall exactly at pixel 63/64 and line 47/48.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_x | input | 10 | Current pixel column |
| line_y | input | 10 | Current line number |
| hsync_n_in | input | 1 | Horizontal sync from generator, active low |
| vsync_n_in | input | 1 | Vertical sync from generator, active low |
| hblank_n_in | input | 1 | Horizontal blanking flag, active low |
| vblank_n_in | input | 1 | Vertical blanking flag, active low |
| red | output | 8 | Red channel to converter |
| green | output | 8 | Green channel to converter |
| blue | output | 8 | Blue channel to converter |
| dac_blank_n | output | 1 | Combined blanking, active low |
| dac_sync_n | output | 1 | Composite sync, active low |
| dac_clk | output | 1 | Inverted pixel clock for converter |
| hsync_n_out | output | 1 | Horizontal sync delayed two clocks |
| vsync_n_out | output | 1 | Vertical sync delayed two clocks |

## Verification
Colour, blanking and composite sync are due one rising edge after the stimulus. The two direct sync pins are due two rising edges after it. The bench changes inputs on the falling edge and reads the one-clock results at the next falling edge. For the sync delay it drives a distinct bit sequence and compares each falling-edge sample with the value driven two falling edges earlier. A one-stage or three-stage delay therefore produces a visible mismatch.

// File: rtl/vga_align_pkg.sv
package vga_align_pkg;
  typedef struct packed {
    logic [7:0] r;
    logic [7:0] g;
    logic [7:0] b;
  } rgb_t;

  localparam rgb_t RGB_BLACK = '{r: 8'h00, g: 8'h00, b: 8'h00};
endpackage

// File: rtl/vga_checker_gen.sv
module vga_checker_gen
  import vga_align_pkg::*;
#(
  parameter int   XW      = 10,
  parameter int   YW      = 10,
  parameter int   TILE_W  = 64,
  parameter int   TILE_H  = 48,
  parameter rgb_t COLOR_E = '{r: 8'h20, g: 8'hC0, b: 8'hF0},
  parameter rgb_t COLOR_O = '{r: 8'hF0, g: 8'h80, b: 8'h10}
) (
  input  logic [XW-1:0] pix_x,
  input  logic [YW-1:0] line_y,
  output rgb_t          color
);
  logic odd_tile;

  // Tile parity is the sum of the column and row tile indices, modulo 2.
  always_comb begin
    odd_tile = (((32'(pix_x) / TILE_W) + (32'(line_y) / TILE_H)) % 2) != 0;
    color    = odd_tile ? COLOR_O : COLOR_E;
  end
endmodule

// File: rtl/vga_sync_delay.sv
module vga_sync_delay #(
  parameter int WIDTH = 2,
  parameter int DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] tap [DEPTH+1];

  assign tap[0] = d;

  // One register per stage; each stage idles at the inactive (high) level.
  for (genvar s = 0; s < DEPTH; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) tap[s+1] <= '1;
      else     tap[s+1] <= tap[s];
    end
  end

  assign q = tap[DEPTH];
endmodule

// File: rtl/vga_dac_align.sv
module vga_dac_align
  import vga_align_pkg::*;
#(
  parameter int   XW        = 10,
  parameter int   YW        = 10,
  parameter int   TILE_W    = 64,
  parameter int   TILE_H    = 48,
  parameter int   DAC_LAT   = 2,
  parameter rgb_t COLOR_E   = '{r: 8'h20, g: 8'hC0, b: 8'hF0},
  parameter rgb_t COLOR_O   = '{r: 8'hF0, g: 8'h80, b: 8'h10}
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [XW-1:0] pix_x,
  input  logic [YW-1:0] line_y,
  input  logic          hsync_n_in,
  input  logic          vsync_n_in,
  input  logic          hblank_n_in,
  input  logic          vblank_n_in,
  output logic [7:0]    red,
  output logic [7:0]    green,
  output logic [7:0]    blue,
  output logic          dac_blank_n,
  output logic          dac_sync_n,
  output logic          dac_clk,
  output logic          hsync_n_out,
  output logic          vsync_n_out
);
  localparam int NSYNC = 2;

  rgb_t             tile_color;
  rgb_t             rgb_q;
  logic             blank_q;
  logic             csync_q;
  logic [NSYNC-1:0] sync_dly;
  logic             visible;

  vga_checker_gen #(
    .XW(XW), .YW(YW), .TILE_W(TILE_W), .TILE_H(TILE_H),
    .COLOR_E(COLOR_E), .COLOR_O(COLOR_O)
  ) u_pattern (
    .pix_x (pix_x),
    .line_y(line_y),
    .color (tile_color)
  );

  assign visible = hblank_n_in & vblank_n_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      rgb_q   <= RGB_BLACK;
      blank_q <= 1'b0;
      csync_q <= 1'b1;
    end else begin
      rgb_q   <= visible ? tile_color : RGB_BLACK;
      blank_q <= visible;
      csync_q <= ~(hsync_n_in ^ vsync_n_in);
    end
  end

  vga_sync_delay #(.WIDTH(NSYNC), .DEPTH(DAC_LAT)) u_sync_dly (
    .clk(clk),
    .rst(rst),
    .d  ({vsync_n_in, hsync_n_in}),
    .q  (sync_dly)
  );

  assign red         = rgb_q.r;
  assign green       = rgb_q.g;
  assign blue        = rgb_q.b;
  assign dac_blank_n = blank_q;
  assign dac_sync_n  = csync_q;
  assign dac_clk     = ~clk;
  assign hsync_n_out = sync_dly[0];
  assign vsync_n_out = sync_dly[1];
endmodule

// File: rtl/vga_dac_align_chk.sv
module vga_dac_align_chk (
  input logic       clk,
  input logic       rst,
  input logic       hsync_n_in,
  input logic       vsync_n_in,
  input logic       hblank_n_in,
  input logic       vblank_n_in,
  input logic [7:0] red,
  input logic [7:0] green,
  input logic [7:0] blue,
  input logic       dac_blank_n,
  input logic       dac_sync_n,
  input logic       hsync_n_out,
  input logic       vsync_n_out
);
  logic [1:0] since_rst;

  always_ff @(posedge clk) begin
    if (rst)                 since_rst <= 2'd0;
    else if (since_rst != 3) since_rst <= since_rst + 2'd1;
  end

  p_blank_and_r2: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 1) |-> (dac_blank_n == $past(hblank_n_in & vblank_n_in)));

  p_csync_xnor_r3: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 1) |-> (dac_sync_n == !($past(hsync_n_in) ^ $past(vsync_n_in))));

  p_hsync_delay_r4: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 2) |-> (hsync_n_out == $past(hsync_n_in, 2)));

  p_vsync_delay_r4: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 2) |-> (vsync_n_out == $past(vsync_n_in, 2)));

  p_dark_in_blank_r5: assert property (@(posedge clk) disable iff (rst)
    ((since_rst >= 1) && !$past(hblank_n_in && vblank_n_in))
      |-> ({red, green, blue} == 24'h0));

  p_reset_idle_r7: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (hsync_n_out && vsync_n_out && dac_sync_n && !dac_blank_n));
endmodule

bind vga_dac_align vga_dac_align_chk u_chk (
  .clk(clk), .rst(rst),
  .hsync_n_in(hsync_n_in), .vsync_n_in(vsync_n_in),
  .hblank_n_in(hblank_n_in), .vblank_n_in(vblank_n_in),
  .red(red), .green(green), .blue(blue),
  .dac_blank_n(dac_blank_n), .dac_sync_n(dac_sync_n),
  .hsync_n_out(hsync_n_out), .vsync_n_out(vsync_n_out)
);

// File: tb/tb_vga_dac_align.sv
`timescale 1ns/1ps
module tb_vga_dac_align;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [9:0] pix_x = '0;
  logic [9:0] line_y = '0;
  logic       hs = 1'b1, vs = 1'b1, hb = 1'b1, vb = 1'b1;
  logic [7:0] red, green, blue;
  logic       dac_blank_n, dac_sync_n, dac_clk, hsync_n_out, vsync_n_out;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  vga_dac_align dut (
    .clk(clk), .rst(rst), .pix_x(pix_x), .line_y(line_y),
    .hsync_n_in(hs), .vsync_n_in(vs), .hblank_n_in(hb), .vblank_n_in(vb),
    .red(red), .green(green), .blue(blue),
    .dac_blank_n(dac_blank_n), .dac_sync_n(dac_sync_n), .dac_clk(dac_clk),
    .hsync_n_out(hsync_n_out), .vsync_n_out(vsync_n_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] tile_rgb(input int x, input int y);
    return (((x / 64) + (y / 48)) % 2 != 0) ? 24'hF08010 : 24'h20C0F0;
  endfunction

  // Drive at falling edge, result due one rising edge later, read at next falling edge.
  task automatic step1(input int x, input int y);
    pix_x  = 10'(x);
    line_y = 10'(y);
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst = 1'b1; hs = 1'b0; vs = 1'b1; hb = 1'b1; vb = 1'b1;
    repeat (2) @(negedge clk);
    check("R7 rgb", {8'h0, red, green, blue}, 32'h0);
    check("R7 blank", dac_blank_n, 0);
    check("R7 csync", dac_sync_n, 1);
    check("R7 syncs", {hsync_n_out, vsync_n_out}, 2'b11);
    rst = 1'b0; hs = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_pattern();
    int xs [8] = '{0, 63, 64, 0, 0, 64, 639, 600};
    int ys [8] = '{0, 0, 0, 47, 48, 48, 479, 0};
    hb = 1'b1; vb = 1'b1;
    for (int i = 0; i < 8; i++) begin
      step1(xs[i], ys[i]);
      check((i inside {1, 2, 3, 4}) ? "R9 tile edge" : "R1 tile colour",
            {8'h0, red, green, blue}, {8'h0, tile_rgb(xs[i], ys[i])});
    end
  endtask

  task automatic t_blank();
    logic [1:0] pat [3] = '{2'b01, 2'b10, 2'b00};
    for (int i = 0; i < 3; i++) begin
      hb = pat[i][1]; vb = pat[i][0];
      step1(64, 0);
      check("R2 blank AND", dac_blank_n, 0);
      check("R5 dark in blank", {8'h0, red, green, blue}, 32'h0);
    end
    hb = 1'b1; vb = 1'b1;
    step1(64, 0);
    check("R2 blank AND", dac_blank_n, 1);
  endtask

  task automatic t_csync();
    for (int i = 0; i < 4; i++) begin
      hs = i[1]; vs = i[0];
      step1(130, 50);
      check("R3 composite sync", dac_sync_n, !(i[1] ^ i[0]));
      check("R8 rgb ignores sync", {8'h0, red, green, blue}, {8'h0, tile_rgb(130, 50)});
    end
    hs = 1'b1; vs = 1'b1;
  endtask

  task automatic t_delay();
    logic [7:0] hseq = 8'b10110010;
    logic [7:0] vseq = 8'b01101101;
    for (int i = 0; i < 8; i++) begin
      if (i >= 2) begin
        check("R4 hsync delay", hsync_n_out, hseq[i-2]);
        check("R4 vsync delay", vsync_n_out, vseq[i-2]);
      end
      hs = hseq[i]; vs = vseq[i];
      @(negedge clk);
    end
    hs = 1'b1; vs = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_dac_clk();
    @(negedge clk); #1;
    check("R6 dac_clk low phase", dac_clk, 1);
    @(posedge clk); #1;
    check("R6 dac_clk high phase", dac_clk, 0);
    @(negedge clk);
  endtask

  initial begin
    #(20 * 200000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_pattern();
    t_blank();
    t_csync();
    t_delay();
    t_dac_clk();
    t_reset();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule